// File: doc/BRIEF.md
# Bidirectional Barrel Shifter and Rotator

This block shifts or rotates a W-bit operand by any amount from 0 to W-1 in one pass through combinational logic. W is a power of two. It provides logical, arithmetic and rotate operations in both directions. The datapath contains only one right-moving logarithmic core. Left operations reverse the bit order of the operand before the core and reverse the core's output again afterwards.

Two flags are produced alongside the result. An overflow flag reports that a left arithmetic shift has lost significant bits. A zero flag reports an all-zero result. A parameter selects whether the result and the flags are registered once before they reach the outputs.

Top module: `revshift_unit`

## Requirements
- R1: Opcode 000 (logical right) returns the operand shifted right by `amount`, with zeros filling the upper `amount` bits.
- R2: Opcode 001 (arithmetic right) returns the operand shifted right by `amount`, with the operand MSB filling the upper `amount` bits.
- R3: Opcode 010 (rotate right) returns the operand rotated right by `amount`. The low `amount` bits wrap into the top.
- R4: Opcode 100 (logical left) returns the operand shifted left by `amount`, with zeros in the low `amount` bits.
- R5: Opcode 101 (arithmetic left) returns the logical-left result with bit W-1 replaced by the operand MSB.
- R6: Opcode 110 (rotate left) returns the operand rotated left by `amount`. The high `amount` bits wrap into the bottom.
- R7: Opcodes 011 and 111 behave exactly as 010 and 110 respectively. The opcode bit order is {left, rotate, arithmetic}, with left at bit 2.
- R8: `ovf` is 1 only for opcode 101, and only when one of operand bits W-2 down to W-1-`amount` differs from bit W-1. An amount of 0 never sets it.
- R9: `zero` is 1 exactly when every bit of `res_y` is 0.
- R10: With OUT_REG=1, outputs reflect the inputs sampled at the previous rising clock edge. A synchronous active-high `rst` clears all outputs to 0.
- R11: An amount of 0 returns the operand unchanged for every opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | W | Operand |
| amount | input | log2(W) | Shift or rotate distance |
| opcode | input | 3 | {left, rotate, arithmetic} |
| res_y | output | W | Shifted or rotated result |
| ovf | output | 1 | Left-arithmetic overflow flag |
| zero | output | 1 | Result-is-zero flag |

## Verification
The assertions check the following properties on every cycle:
- Overflow never appears outside the left-arithmetic opcode.
- A zero amount returns the operand and raises no overflow.
- Left-arithmetic results keep the operand sign bit.
- Bits vacated by logical and left shifts are zero.
- The registered outputs follow the combinational result one cycle later.

The exact bit placement of each rotate and arithmetic-right fill, the behaviour of the aliased opcodes, and the exact overflow boundary are shown only by the bench. It sweeps every operand, amount and opcode of an 8-bit instance and compares each result against values it computes arithmetically.

// File: rtl/revshift_pkg.sv
package revshift_pkg;

    typedef struct packed {
        logic left;
        logic rotate;
        logic arith;
    } opcode_t;

    typedef struct packed {
        logic left;
        logic rotate;
        logic sra;
        logic sla;
    } shctl_t;

    function automatic shctl_t decode_op(opcode_t op);
        shctl_t c;
        c.left   = op.left;
        c.rotate = op.rotate;
        c.sra    = !op.left && !op.rotate && op.arith;
        c.sla    =  op.left && !op.rotate && op.arith;
        return c;
    endfunction

endpackage

// File: rtl/revshift_decode.sv
module revshift_decode
    import revshift_pkg::*;
(
    input  opcode_t op,
    output shctl_t  ctl
);
    always_comb ctl = decode_op(op);
endmodule

// File: rtl/revshift_reverse.sv
module revshift_reverse #(
    parameter int W = 32
) (
    input  logic         rev,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = rev ? din[W-1-i] : din[i];
    end
endmodule

// File: rtl/revshift_core.sv
module revshift_core #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    input  logic          rotate,
    input  logic          fill,
    output logic [W-1:0]  dout
);
    logic [SW:0][W-1:0] stg;

    assign stg[0] = din;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int D = 1 << k;
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (i < W - D) begin : g_mid
                assign stg[k+1][i] = amt[k] ? stg[k][i+D] : stg[k][i];
            end else begin : g_top
                assign stg[k+1][i] = amt[k] ? (rotate ? stg[k][i+D-W] : fill)
                                            : stg[k][i];
            end
        end
    end

    assign dout = stg[SW];
endmodule

// File: rtl/revshift_flags.sv
module revshift_flags #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  op_a,
    input  logic [SW-1:0] amt,
    input  logic          sla,
    input  logic [W-1:0]  res,
    output logic          ovf,
    output logic          zero
);
    logic [W-2:0] lost;

    for (genvar i = 0; i < W - 1; i++) begin : g_lost
        assign lost[i] = (op_a[i] ^ op_a[W-1]) && ((i + int'(amt)) >= (W - 1));
    end

    assign ovf  = sla && (|lost);
    assign zero = ~|res;
endmodule

// File: rtl/revshift_unit.sv
module revshift_unit
    import revshift_pkg::*;
#(
    parameter int W       = 32,
    parameter int OUT_REG = 1,
    localparam int SW     = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  op_a,
    input  logic [SW-1:0] amount,
    input  logic [2:0]    opcode,
    output logic [W-1:0]  res_y,
    output logic          ovf,
    output logic          zero
);
    shctl_t       ctl;
    logic [W-1:0] pre_rev;
    logic [W-1:0] core_out;
    logic [W-1:0] post_rev;
    logic [W-1:0] res_c;
    logic         fill_bit;
    logic         ovf_c;
    logic         zero_c;

    revshift_decode u_dec (
        .op  (opcode_t'(opcode)),
        .ctl (ctl)
    );

    assign fill_bit = ctl.sra & op_a[W-1];

    revshift_reverse #(.W(W)) u_rev_in (
        .rev  (ctl.left),
        .din  (op_a),
        .dout (pre_rev)
    );

    revshift_core #(.W(W), .SW(SW)) u_core (
        .din    (pre_rev),
        .amt    (amount),
        .rotate (ctl.rotate),
        .fill   (fill_bit),
        .dout   (core_out)
    );

    revshift_reverse #(.W(W)) u_rev_out (
        .rev  (ctl.left),
        .din  (core_out),
        .dout (post_rev)
    );

    assign res_c = ctl.sla ? {op_a[W-1], post_rev[W-2:0]} : post_rev;

    revshift_flags #(.W(W), .SW(SW)) u_flags (
        .op_a (op_a),
        .amt  (amount),
        .sla  (ctl.sla),
        .res  (res_c),
        .ovf  (ovf_c),
        .zero (zero_c)
    );

    if (OUT_REG != 0) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                res_y <= '0;
                ovf   <= 1'b0;
                zero  <= 1'b0;
            end else begin
                res_y <= res_c;
                ovf   <= ovf_c;
                zero  <= zero_c;
            end
        end

        // R10: registered outputs track the combinational result one cycle later
        a_r10_reg_follow: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (res_y == $past(res_c)) && (ovf == $past(ovf_c)) && (zero == $past(zero_c)));
    end else begin : g_comb
        assign res_y = res_c;
        assign ovf   = ovf_c;
        assign zero  = zero_c;
    end

    // R8: overflow only for left arithmetic
    a_r8_ovf_only_sla: assert property (@(posedge clk) disable iff (rst)
        ovf_c |-> (opcode == 3'b101));

    // R8/R11: zero amount never overflows and passes the operand
    a_r11_zero_amount: assert property (@(posedge clk) disable iff (rst)
        (amount == '0) |-> (res_c == op_a) && !ovf_c);

    // R5: left arithmetic keeps the sign bit
    a_r5_sign_kept: assert property (@(posedge clk) disable iff (rst)
        (opcode == 3'b101) |-> (res_c[W-1] == op_a[W-1]));

    // R4: low bits vacated by left shifts are zero
    a_r4_low_zero: assert property (@(posedge clk) disable iff (rst)
        (opcode[2:1] == 2'b10) |-> ((res_c & ~({W{1'b1}} << amount)) == '0));

    // R1: high bits vacated by logical right shift are zero
    a_r1_high_zero: assert property (@(posedge clk) disable iff (rst)
        (opcode == 3'b000) |-> ((res_c & ~({W{1'b1}} >> amount)) == '0));

endmodule

// File: tb/revshift_unit_tb_top.sv
`timescale 1ns/1ps
module revshift_unit_tb_top;
    localparam int W  = 8;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  op_a = '0;
    logic [SW-1:0] amount = '0;
    logic [2:0]    opcode = '0;
    logic [W-1:0]  res_y;
    logic          ovf;
    logic          zero;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    revshift_unit #(.W(W), .OUT_REG(1)) dut_i (
        .clk    (clk),
        .rst    (rst),
        .op_a   (op_a),
        .amount (amount),
        .opcode (opcode),
        .res_y  (res_y),
        .ovf    (ovf),
        .zero   (zero)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s a=%02h b=%0d op=%0d actual=%0h expected=%0h",
                     req, op_a, amount, opcode, act, exp);
        end
    endtask

    function automatic string op_req(input int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic int expect_y(input int a, input int b, input int op);
        int r;
        int sll;
        sll = (a << b) & 8'hff;
        case (op)
            0: r = a >> b;
            1: r = ((a >> b) | ((a & 8'h80) != 0 ? ((8'hff << (8 - b)) & 8'hff) : 0)) & 8'hff;
            2, 3: r = ((a >> b) | (a << (8 - b))) & 8'hff;
            4: r = sll;
            5: r = (a & 8'h80) | (sll & 8'h7f);
            default: r = ((a << b) | (a >> (8 - b))) & 8'hff;
        endcase
        return r;
    endfunction

    function automatic int expect_ovf(input int a, input int b, input int op);
        int sgn;
        int o;
        o = 0;
        sgn = (a >> 7) & 1;
        if (op == 5) begin
            for (int i = 7 - b; i <= 6; i++) begin
                if (((a >> i) & 1) != sgn) o = 1;
            end
        end
        return o;
    endfunction

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        op_a   = 8'hff;
        amount = 3'd1;
        opcode = 3'b000;
        repeat (3) @(negedge clk);
        // R10: reset clears outputs
        check("R10", {23'd0, zero, ovf, res_y}, 0);
        rst = 1'b0;
        @(negedge clk);
        // R10: one-cycle latency
        check("R10", res_y, 8'h7f);

        for (int op = 0; op < 8; op++) begin
            for (int b = 0; b < W; b++) begin
                for (int a = 0; a < 256; a++) begin
                    int ey;
                    op_a   = a[7:0];
                    amount = b[2:0];
                    opcode = op[2:0];
                    ey = expect_y(a, b, op);
                    @(negedge clk);
                    check(op_req(op), res_y, ey);
                    check("R8", ovf, expect_ovf(a, b, op));
                    check("R9", zero, (ey == 0) ? 1 : 0);
                    if (b == 0) check("R11", res_y, a);
                end
            end
        end

        rst = 1'b1;
        @(negedge clk);
        check("R10", {23'd0, zero, ovf, res_y}, 0);
        finish_run();
    end
endmodule